// File: doc/BRIEF.md
# Two-Mode Burst Address Sequencer

This block produces the array address for a four-beat burst. When a burst starts, it registers the external address. It then walks the two least significant bits through four beats. The upper bits come straight from the registered start address. A small beat counter is cleared at the start of each burst and steps on every clock where the active-low advance input is asserted. A hold on advance stretches the current beat, so the requester can insert wait states.

A mode input selects how the beat count maps onto the low bits:

- **Interleaved order:** each low bit is the start bit XORed with the count. This is the usual order for cache line fills.
- **Linear order:** the low bits count upward from the start and wrap modulo four.

In both modes the sequence wraps inside the four-word block and never carries into the upper bits.

Top module: `burst_addr_seq`

## Requirements
- R1: On the clock edge after `load_i` is sampled high, `addr_o` equals the `addr_i` value sampled at that edge, in either mode. This is the first beat.
- R2: A load clears the beat count to zero, and it takes priority over an asserted advance in the same cycle.
- R3: On an edge where `load_i` is low and `adv_ni` is low, the sequence moves one beat forward.
- R4: On an edge where `load_i` is low and `adv_ni` is high, `addr_o` keeps its value while `mode_i` is unchanged.
- R5: Bits `ADDR_W-1` down to 2 of `addr_o` always equal the same bits of the last loaded address, and they never change during a burst.
- R6: With `mode_i` = 1 the low two bits are the start bits XOR the count. Starting from 00 the beats are 00, 01, 10, 11; from 01 they are 01, 00, 11, 10; from 10 they are 10, 11, 00, 01; from 11 they are 11, 10, 01, 00.
- R7: With `mode_i` = 0 the low two bits are (start + count) mod 4. For example, from 10 the beats are 10, 11, 00, 01.
- R8: An advance after the fourth beat returns the low bits to the start value in both modes.
- R9: While `rst_ni` is low, `addr_o` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Start a burst from `addr_i` |
| adv_ni | input | 1 | Advance to next beat, active low |
| mode_i | input | 1 | 1 = interleaved order, 0 = linear order |
| addr_i | input | ADDR_W | External start address |
| addr_o | output | ADDR_W | Array address for the current beat |

## Verification
The assertions assume that `load_i`, `adv_ni` and `addr_i` are known at every sampled edge. They also assume that `mode_i` stays fixed for the length of a burst. For that reason the hold check is waived on any cycle where `mode_i` moved.

The stimulus changes every input only on falling clock edges. It sets `mode_i` together with the load and leaves it alone until the next load. It keeps `adv_ni` high through reset, so the state leaving reset is the zero start address at beat zero.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  typedef enum logic {
    ORDER_LINEAR     = 1'b0,
    ORDER_INTERLEAVE = 1'b1
  } burst_order_e;
endpackage

// File: rtl/bseq_start_reg.sv
module bseq_start_reg #(
  parameter int ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] start_o
);
  logic [ADDR_W-1:0] start_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     start_q <= '0;
    else if (load_i) start_q <= addr_i;
  end

  assign start_o = start_q;

  AST_START_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(start_o)); // R5
endmodule

// File: rtl/bseq_beat_ctr.sv
module bseq_beat_ctr #(
  parameter int BEAT_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              adv_ni,
  output logic [BEAT_W-1:0] cnt_o
);
  logic [BEAT_W-1:0] cnt_q;

  // load wins over advance
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (load_i)  cnt_q <= '0;
    else if (!adv_ni) cnt_q <= cnt_q + BEAT_W'(1);
  end

  assign cnt_o = cnt_q;

  AST_CLEAR_ON_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_o == '0)); // R2
  AST_STEP_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !adv_ni) |=> (cnt_o == BEAT_W'($past(cnt_o) + BEAT_W'(1)))); // R3
  AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && adv_ni) |=> $stable(cnt_o)); // R4
endmodule

// File: rtl/bseq_order_map.sv
module bseq_order_map
  import burst_seq_pkg::*;
#(
  parameter int BEAT_W = 2
) (
  input  logic [BEAT_W-1:0] start_i,
  input  logic [BEAT_W-1:0] cnt_i,
  input  burst_order_e      order_i,
  output logic [BEAT_W-1:0] low_o
);
  logic [BEAT_W-1:0] ilv;
  logic [BEAT_W-1:0] lin;

  for (genvar b = 0; b < BEAT_W; b++) begin : g_ilv
    assign ilv[b] = start_i[b] ^ cnt_i[b];
  end

  // wraps inside the block, no carry out
  assign lin   = start_i + cnt_i;
  assign low_o = (order_i == ORDER_INTERLEAVE) ? ilv : lin;

  always_comb begin
    if (cnt_i == '0) begin
      AST_BEAT0_IS_START: assert (low_o == start_i); // R1
    end
  end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BEAT_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              adv_ni,
  input  logic              mode_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int UPPER_W = ADDR_W - BEAT_W;

  logic [ADDR_W-1:0] start_q;
  logic [BEAT_W-1:0] cnt;
  logic [BEAT_W-1:0] low;
  burst_order_e      order;

  assign order = burst_order_e'(mode_i);

  bseq_start_reg #(.ADDR_W(ADDR_W)) i_start (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load_i),
    .addr_i  (addr_i),
    .start_o (start_q)
  );

  bseq_beat_ctr #(.BEAT_W(BEAT_W)) i_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load_i),
    .adv_ni (adv_ni),
    .cnt_o  (cnt)
  );

  bseq_order_map #(.BEAT_W(BEAT_W)) i_map (
    .start_i (start_q[BEAT_W-1:0]),
    .cnt_i   (cnt),
    .order_i (order),
    .low_o   (low)
  );

  assign addr_o = {start_q[ADDR_W-1:BEAT_W], low};

  AST_FIRST_BEAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (addr_o == $past(addr_i))); // R1
  AST_UPPER_LOADED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (addr_o[ADDR_W-1:BEAT_W] == $past(addr_i[ADDR_W-1:BEAT_W]))); // R5
  AST_UPPER_FIXED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(addr_o[ADDR_W-1:BEAT_W])); // R5
  AST_ADDR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && adv_ni) |=> ((mode_i != $past(mode_i)) || $stable(addr_o))); // R4

  initial begin
    AST_WIDTH_OK: assert (UPPER_W > 0);
  end
endmodule

// File: tb/test_burst_addr_seq.sv
module test_burst_addr_seq;
  localparam int  ADDR_W = 16;
  localparam time CLK_P  = 8ns;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              load = 1'b0;
  logic              adv_n = 1'b1;
  logic              mode = 1'b1;
  logic [ADDR_W-1:0] addr = '0;
  logic [ADDR_W-1:0] addr_o;

  int n_chk = 0;
  int n_err = 0;

  always #(CLK_P/2) clk = ~clk;

  burst_addr_seq #(.ADDR_W(ADDR_W), .BEAT_W(2)) i_burst_addr_seq (
    .clk_i  (clk),
    .rst_ni (rst_ni),
    .load_i (load),
    .adv_ni (adv_n),
    .mode_i (mode),
    .addr_i (addr),
    .addr_o (addr_o)
  );

  function automatic logic [1:0] beat_low(logic [1:0] s, int k, logic m);
    logic [1:0] kk = 2'(k);
    return m ? (s ^ kk) : 2'(s + kk);
  endfunction

  task automatic check(string req, logic [ADDR_W-1:0] exp);
    n_chk++;
    if (addr_o !== exp) begin
      n_err++;
      $display("FAIL %s: addr_o=%h expected=%h", req, addr_o, exp);
    end
  endtask

  // load at next posedge; returns sampled at following negedge
  task automatic start_burst(logic [ADDR_W-1:0] a, logic m, logic adv_during_load);
    load = 1'b1; addr = a; mode = m; adv_n = adv_during_load;
    @(negedge clk);
    load = 1'b0; adv_n = 1'b1; addr = ~a;
  endtask

  task automatic t_reset;
    addr = 16'hbeef;
    repeat (2) @(negedge clk);
    check("R9 reset", '0);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R9 after release", '0);
  endtask

  task automatic run_order(logic m, string req);
    for (int s = 0; s < 4; s++) begin
      logic [ADDR_W-1:0] a = {14'h1a5c + 14'(s), 2'(s)};
      start_burst(a, m, 1'b1);
      check("R1 first beat", a);
      adv_n = 1'b0;
      for (int k = 1; k <= 4; k++) begin
        @(negedge clk);
        if (k == 4) check("R8 wrap", a);
        else check(req, {a[ADDR_W-1:2], beat_low(a[1:0], k, m)});
      end
      adv_n = 1'b1;
    end
  endtask

  task automatic t_hold;
    logic [ADDR_W-1:0] a = 16'h7fff;
    start_burst(a, 1'b0, 1'b1);
    adv_n = 1'b0;
    @(negedge clk);
    check("R3 step", 16'h7ffc);
    adv_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R4 hold", 16'h7ffc);
    check("R5 no carry", 16'h7ffc);
    adv_n = 1'b0;
    @(negedge clk);
    check("R3 resume", 16'h7ffd);
    adv_n = 1'b1;
  endtask

  task automatic t_load_priority;
    logic [ADDR_W-1:0] a = 16'h0402;
    start_burst(16'h3333, 1'b1, 1'b1);
    adv_n = 1'b0;
    @(negedge clk);
    start_burst(a, 1'b1, 1'b0);
    check("R2 load beats advance", a);
    adv_n = 1'b0;
    @(negedge clk);
    check("R2 count cleared", 16'h0403);
    adv_n = 1'b1;
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    run_order(1'b1, "R6 interleave");
    run_order(1'b0, "R7 linear");
    t_hold();
    t_load_priority();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    #(CLK_P * 20000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: run did not finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule